// File: doc/BRIEF.md
# Split Code/Data Address Remapper

This block sits on the physical address path between the memory management unit and the external memory decoder. For every bus cycle it receives the translated 20-bit physical address, the 2-bit bank-select value, the segment class the logical address fell into (root, data, stack or extended window), the upper four logical-address bits and a flag that marks the cycle as an instruction fetch. It forwards the address and bank select, but on data cycles in the root or data segments it can flip physical address bit 16 and the top bank-select bit. Code and data that share one logical address can then reach different devices, and each gets up to 64 KB of logical space.

A patch window register names one 4 KB logical page. A data read or write that hits this page, and that falls in the root or data segment, is decoded as if it were an instruction fetch, so the bytes land where code is fetched from. The window has no effect for stack or extended-window cycles. Three control bits enable the bit-16 flip, the bank-MSB flip and the window separately. Both registers are loaded through a small synchronous write port.

The address path is purely combinational, so it adds no cycle of latency. There is no valid/ready handshake. Each cycle's inputs produce that cycle's outputs, the upstream unit paces the cycles, and there is no back-pressure to honour. Only the write port is clocked.

Top module: `cdsplit_remap`

## Requirements
- R1: After reset all three enables are clear and the window tag is 0, so every cycle passes through unchanged: out_paddr equals cyc_paddr, out_bank equals cyc_bank and out_as_fetch equals cyc_is_fetch.
- R2: When the bit-16 enable (control bit 0) is set, a data cycle in segment class 0 (root) or 1 (data) that is not redirected by the window leaves with out_paddr bit 16 inverted. All other address bits are unchanged.
- R3: When the bank enable (control bit 1) is set, such a data cycle leaves with out_bank bit 1 inverted and out_bank bit 0 unchanged. This bit is independent of the bit-16 enable.
- R4: An instruction fetch (cyc_is_fetch=1) is never inverted, whatever the enables are.
- R5: Cycles with segment class 2 (stack) or 3 (extended window) always pass through unchanged, and out_as_fetch equals cyc_is_fetch for them.
- R6: When the window enable (control bit 2) is set, a data cycle in class 0 or 1 whose cyc_laddr_hi equals the 4-bit window tag is decoded as a fetch. It gives out_as_fetch=1 and no inversion.
- R7: The window is ignored for class 2 and 3 cycles and for data cycles whose cyc_laddr_hi differs from the tag. Such cycles keep out_as_fetch=0.
- R8: Register writes happen on a rising edge with cfg_we=1. Address 0 loads the control bits [2:0], and address 1 loads the window tag [3:0]. Writes to addresses 2 and 3, and any cycle with cfg_we=0, leave both registers unchanged.
- R9: The outputs follow the cycle inputs in the same cycle, with no register on the address path. A new configuration takes effect from the first cycle after the writing edge.
- R10: out_as_fetch is 1 for every instruction fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration registers |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select: 0 control, 1 window tag |
| cfg_wdata | input | 4 | Write data |
| cyc_paddr | input | 20 | Physical address of the current cycle |
| cyc_bank | input | 2 | Bank-select value of the current cycle |
| cyc_seg | input | 2 | Segment class: 0 root, 1 data, 2 stack, 3 extended window |
| cyc_is_fetch | input | 1 | 1 for an instruction fetch, 0 for a data access |
| cyc_laddr_hi | input | 4 | Logical address bits [15:12] |
| out_paddr | output | 20 | Address toward the memory decoder |
| out_bank | output | 2 | Bank select toward the memory decoder |
| out_as_fetch | output | 1 | Cycle type as decoded, after the window |

## Verification
The bench turns on each flip enable by itself. A design that tied the two flips together, or that put the flip on the wrong address bit, shows the wrong out_paddr bit 16 or out_bank bit 1. It sends fetches and stack or extended-window cycles with every enable set. A design that ignored the cycle type or the segment class would then invert them. It places the window tag on a matching page and on a page next to it, in both eligible and ineligible segments. A design that skipped the segment gate, or that compared too few bits, would redirect the wrong cycles. Finally it writes to the unused addresses and presents data with the strobe low. A sloppy address decode would then clear the enables, and the next data cycle would stop inverting.

// File: rtl/cdsplit_pkg.sv
package cdsplit_pkg;
  localparam int WIN_W = 4;

  typedef enum logic [1:0] {
    SEG_ROOT  = 2'd0,
    SEG_DATA  = 2'd1,
    SEG_STACK = 2'd2,
    SEG_XWIN  = 2'd3
  } seg_t;

  typedef struct packed {
    logic             win_en;
    logic             bank_en;
    logic             a16_en;
    logic [WIN_W-1:0] win_tag;
  } cfg_t;

  function automatic logic seg_eligible(input logic [1:0] seg);
    return (seg == SEG_ROOT) || (seg == SEG_DATA);
  endfunction
endpackage

// File: rtl/cdsplit_cfg.sv
module cdsplit_cfg
  import cdsplit_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = WIN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output cfg_t              cfg_q
);
  localparam logic [ADDR_W-1:0] CTRL_SEL = '0;
  localparam logic [ADDR_W-1:0] WIN_SEL  = ADDR_W'(1);

  logic ctrl_hit, win_hit;
  assign ctrl_hit = we && (addr == CTRL_SEL);
  assign win_hit  = we && (addr == WIN_SEL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else begin
      if (ctrl_hit) begin
        cfg_q.a16_en  <= wdata[0];
        cfg_q.bank_en <= wdata[1];
        cfg_q.win_en  <= wdata[2];
      end
      if (win_hit) begin
        cfg_q.win_tag <= wdata[WIN_W-1:0];
      end
    end
  end
endmodule

// File: rtl/cdsplit_window.sv
module cdsplit_window
  import cdsplit_pkg::*;
(
  input  cfg_t             cfg,
  input  logic [1:0]       seg,
  input  logic             is_fetch,
  input  logic [WIN_W-1:0] laddr_hi,
  output logic             eff_fetch,
  output logic             flip_ok
);
  logic in_window;

  always_comb begin
    in_window = cfg.win_en && !is_fetch && seg_eligible(seg) &&
                (laddr_hi == cfg.win_tag);
    eff_fetch = is_fetch || in_window;
    flip_ok   = seg_eligible(seg) && !eff_fetch;
  end
endmodule

// File: rtl/cdsplit_flip.sv
module cdsplit_flip (
  input  logic en,
  input  logic flip_ok,
  input  logic bit_in,
  output logic bit_out
);
  assign bit_out = bit_in ^ (en && flip_ok);
endmodule

// File: rtl/cdsplit_remap.sv
module cdsplit_remap
  import cdsplit_pkg::*;
#(
  parameter int PADDR_W = 20,
  parameter int BANK_W  = 2,
  parameter int A_BIT   = 16,
  parameter int CADDR_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [CADDR_W-1:0] cfg_addr,
  input  logic [WIN_W-1:0]   cfg_wdata,
  input  logic [PADDR_W-1:0] cyc_paddr,
  input  logic [BANK_W-1:0]  cyc_bank,
  input  logic [1:0]         cyc_seg,
  input  logic               cyc_is_fetch,
  input  logic [WIN_W-1:0]   cyc_laddr_hi,
  output logic [PADDR_W-1:0] out_paddr,
  output logic [BANK_W-1:0]  out_bank,
  output logic               out_as_fetch
);
  localparam int BMSB  = BANK_W - 1;
  localparam int LANES = 2;

  cfg_t cfg_q;
  logic flip_ok;
  logic [LANES-1:0] lane_en, lane_in, lane_out;

  cdsplit_cfg #(.ADDR_W(CADDR_W), .DATA_W(WIN_W)) u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .addr  (cfg_addr),
    .wdata (cfg_wdata),
    .cfg_q (cfg_q)
  );

  cdsplit_window u_win (
    .cfg       (cfg_q),
    .seg       (cyc_seg),
    .is_fetch  (cyc_is_fetch),
    .laddr_hi  (cyc_laddr_hi),
    .eff_fetch (out_as_fetch),
    .flip_ok   (flip_ok)
  );

  // lane 0: physical address bit; lane 1: bank-select MSB
  assign lane_en = {cfg_q.bank_en, cfg_q.a16_en};
  assign lane_in = {cyc_bank[BMSB], cyc_paddr[A_BIT]};

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    cdsplit_flip u_flip (
      .en      (lane_en[g]),
      .flip_ok (flip_ok),
      .bit_in  (lane_in[g]),
      .bit_out (lane_out[g])
    );
  end

  always_comb begin
    out_paddr        = cyc_paddr;
    out_paddr[A_BIT] = lane_out[0];
    out_bank         = cyc_bank;
    out_bank[BMSB]   = lane_out[1];
  end
endmodule

// File: rtl/cdsplit_remap_chk.sv
module cdsplit_remap_chk
  import cdsplit_pkg::*;
#(
  parameter int PADDR_W = 20,
  parameter int BANK_W  = 2,
  parameter int A_BIT   = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cfg_we,
  input cfg_t               cfg_q,
  input logic [PADDR_W-1:0] cyc_paddr,
  input logic [BANK_W-1:0]  cyc_bank,
  input logic [1:0]         cyc_seg,
  input logic               cyc_is_fetch,
  input logic [PADDR_W-1:0] out_paddr,
  input logic [BANK_W-1:0]  out_bank,
  input logic               out_as_fetch
);
  logic written;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) written <= 1'b0;
    else if (cfg_we) written <= 1'b1;
  end

  logic thru;
  assign thru = (out_paddr == cyc_paddr) && (out_bank == cyc_bank);

  assert_reset_thru_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !written |-> thru && (out_as_fetch == cyc_is_fetch));

  assert_a16_flip_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q.a16_en && !out_as_fetch && seg_eligible(cyc_seg))
      |-> out_paddr[A_BIT] != cyc_paddr[A_BIT]);

  assert_bank_flip_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q.bank_en && !out_as_fetch && seg_eligible(cyc_seg))
      |-> out_bank[BANK_W-1] != cyc_bank[BANK_W-1]);

  assert_fetch_thru_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_is_fetch |-> thru);

  assert_seg_thru_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !seg_eligible(cyc_seg) |-> thru && (out_as_fetch == cyc_is_fetch));

  assert_fetch_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_is_fetch |-> out_as_fetch);
endmodule

bind cdsplit_remap cdsplit_remap_chk #(
  .PADDR_W(PADDR_W), .BANK_W(BANK_W), .A_BIT(A_BIT)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_we       (cfg_we),
  .cfg_q        (cfg_q),
  .cyc_paddr    (cyc_paddr),
  .cyc_bank     (cyc_bank),
  .cyc_seg      (cyc_seg),
  .cyc_is_fetch (cyc_is_fetch),
  .out_paddr    (out_paddr),
  .out_bank     (out_bank),
  .out_as_fetch (out_as_fetch)
);

// File: tb/cdsplit_remap_tb.sv
module cdsplit_remap_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [3:0]  cfg_wdata = '0;
  logic [19:0] cyc_paddr = '0;
  logic [1:0]  cyc_bank = '0;
  logic [1:0]  cyc_seg = '0;
  logic        cyc_is_fetch = 1'b0;
  logic [3:0]  cyc_laddr_hi = '0;
  logic [19:0] out_paddr;
  logic [1:0]  out_bank;
  logic        out_as_fetch;

  int checks = 0;
  int errors = 0;

  // shadow configuration, kept from the requirements
  logic m_a16, m_bank, m_win;
  logic [3:0] m_tag;

  always #2 clk = ~clk;

  cdsplit_remap u_dut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [3:0] d, input logic we);
    @(negedge clk);
    cfg_we = we; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (we && a == 2'd0) begin m_a16 = d[0]; m_bank = d[1]; m_win = d[2]; end
    if (we && a == 2'd1) m_tag = d;
  endtask

  task automatic cyc_check(input string req, input logic [19:0] pa, input logic [1:0] bk,
                           input logic [1:0] sg, input logic f, input logic [3:0] lh);
    logic redir, flip;
    logic [19:0] epa;
    logic [1:0] ebk;
    cyc_paddr = pa; cyc_bank = bk; cyc_seg = sg; cyc_is_fetch = f; cyc_laddr_hi = lh;
    #1;
    redir = m_win && !f && sg < 2 && lh == m_tag;
    flip  = sg < 2 && !f && !redir;
    epa = pa; ebk = bk;
    if (flip && m_a16) epa[16] = ~pa[16];
    if (flip && m_bank) ebk[1] = ~bk[1];
    check({req, " paddr"}, 32'(out_paddr), 32'(epa));
    check({req, " bank"}, 32'(out_bank), 32'(ebk));
    check({req, " as_fetch"}, 32'(out_as_fetch), 32'(f || redir));
  endtask

  task automatic t_reset;   // R1
    cyc_check("R1 root data", 20'h1_2345, 2'b10, 2'd0, 1'b0, 4'h3);
    check("R1 a16 literal", 32'(out_paddr[16]), 32'd1);
    cyc_check("R1 data seg", 20'h0_0000, 2'b01, 2'd1, 1'b0, 4'h0);
  endtask

  task automatic t_a16_only;   // R2
    wr(2'd0, 4'b0001, 1'b1);
    cyc_check("R2 root", 20'h1_ABCD, 2'b10, 2'd0, 1'b0, 4'h1);
    check("R2 a16 literal", 32'(out_paddr[16]), 32'd0);
    check("R2 bank untouched", 32'(out_bank), 32'd2);
    cyc_check("R2 data", 20'h8_0000, 2'b00, 2'd1, 1'b0, 4'h9);
  endtask

  task automatic t_bank_only;   // R3
    wr(2'd0, 4'b0010, 1'b1);
    cyc_check("R3 root", 20'h1_0000, 2'b01, 2'd0, 1'b0, 4'h2);
    check("R3 bank literal", 32'(out_bank), 32'd3);
    check("R3 a16 untouched", 32'(out_paddr[16]), 32'd1);
  endtask

  task automatic t_fetch;   // R4 R10
    wr(2'd0, 4'b0011, 1'b1);
    cyc_check("R4 fetch root", 20'h1_1111, 2'b11, 2'd0, 1'b1, 4'h1);
    check("R10 fetch flag", 32'(out_as_fetch), 32'd1);
    cyc_check("R4 fetch data", 20'h0_2222, 2'b00, 2'd1, 1'b1, 4'h2);
  endtask

  task automatic t_seg;   // R5
    cyc_check("R5 stack", 20'h1_F000, 2'b10, 2'd2, 1'b0, 4'hD);
    check("R5 stack literal", 32'(out_paddr[16]), 32'd1);
    cyc_check("R5 xwin", 20'h5_0000, 2'b00, 2'd3, 1'b0, 4'hE);
    cyc_check("R5 xwin fetch", 20'h5_0000, 2'b00, 2'd3, 1'b1, 4'hE);
  endtask

  task automatic t_window;   // R6 R7
    wr(2'd1, 4'h5, 1'b1);
    wr(2'd0, 4'b0111, 1'b1);
    cyc_check("R6 hit root", 20'h1_5000, 2'b10, 2'd0, 1'b0, 4'h5);
    check("R6 redirect literal", 32'(out_as_fetch), 32'd1);
    cyc_check("R6 hit data", 20'h0_5000, 2'b00, 2'd1, 1'b0, 4'h5);
    cyc_check("R7 neighbour page", 20'h1_6000, 2'b10, 2'd0, 1'b0, 4'h4);
    check("R7 miss literal", 32'(out_as_fetch), 32'd0);
    cyc_check("R7 stack in tag", 20'h1_5000, 2'b10, 2'd2, 1'b0, 4'h5);
    cyc_check("R7 xwin in tag", 20'h1_5000, 2'b10, 2'd3, 1'b0, 4'h5);
    cyc_check("R7 tag msb differs", 20'h1_D000, 2'b10, 2'd0, 1'b0, 4'hD);
  endtask

  task automatic t_ignored;   // R8 R9
    wr(2'd2, 4'h0, 1'b1);
    wr(2'd3, 4'h0, 1'b1);
    wr(2'd0, 4'h0, 1'b0);
    wr(2'd1, 4'h0, 1'b0);
    cyc_check("R8 ctrl kept", 20'h1_0000, 2'b10, 2'd0, 1'b0, 4'h1);
    check("R8 still flips", 32'(out_paddr[16]), 32'd0);
    cyc_check("R8 tag kept", 20'h1_0000, 2'b10, 2'd0, 1'b0, 4'h5);
    check("R8 tag literal", 32'(out_as_fetch), 32'd1);
    // R9: change only the inputs mid-cycle; output follows at once
    cyc_paddr = 20'h0_0000; #1;
    check("R9 comb follow", 32'(out_paddr[16]), 32'd0);
    cyc_paddr = 20'h1_0000; cyc_laddr_hi = 4'h1; #1;
    check("R9 comb follow 2", 32'(out_paddr[16]), 32'd0);
  endtask

  task automatic t_sweep;   // R2 R3 R4 R5 R6 R7 R10
    for (int c = 0; c < 8; c++) begin
      wr(2'd0, 4'(c), 1'b1);
      for (int s = 0; s < 4; s++)
        for (int f = 0; f < 2; f++)
          for (int h = 4; h < 7; h++)
            cyc_check("R2 R3 R6 sweep", 20'(h * 20'h1_1000 + s), 2'(h), 2'(s), f[0], 4'(h));
    end
  endtask

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    m_a16 = 0; m_bank = 0; m_win = 0; m_tag = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_a16_only();
    t_bank_only();
    t_fetch();
    t_seg();
    t_window();
    t_ignored();
    t_sweep();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule